// File: doc/BRIEF.md
# Floating-point access permission gate

This block sits beside the issue stage of a processor core. It decides, for every issued instruction that targets the floating-point or SIMD unit, whether that instruction may run. If it may not, the block raises an undefined-instruction fault instead. The fault carries a qualifier saying the cause is disabled access, which keeps it apart from faults for unknown encodings.

The decision draws on two control registers that the block holds. The first is an access-control register. Its two-bit permission tier grants access in every mode or in privileged modes only, and it also holds a bit that switches SIMD off. The second is a floating-point exception register, which carries the global enable bit.

The permission checks are tiered. Moves to or from floating-point system registers check only the tier and the processor mode. Floating-point data operations also need the enable bit. SIMD operations need all of that and also need the SIMD-off bit clear. A one-cycle startup request opens access for the whole unit.

Top module: `fp_access_gate`

## Requirements
- R1: After reset, both register readbacks are 0 and `allow` and `undef_fault` are low.
- R2: With tier field `acr_rd[21:20]` = 3, an instruction whose other conditions are met is allowed in every mode, user mode included.
- R3: With tier = 2, access is granted only when `cpu_mode` differs from the user code 5'b10000. Tier values 0 and 1 deny access in every mode.
- R4: A floating-point data operation (class 2'b01) is allowed only when the tier permits and the enable bit `fpx_rd[30]` is 1.
- R5: A system-register move (class 2'b10) depends only on the tier and the mode. The enable bit has no effect on it.
- R6: A SIMD operation (class 2'b11) is allowed only under the class 2'b01 conditions and with the SIMD-off bit `acr_rd[31]` at 0.
- R7: The verdict appears on `allow`/`undef_fault` exactly one cycle after `insn_valid`, for one cycle. Without a strobe, or for class 2'b00, both outputs stay low. A register write in the same cycle as a strobe affects only later instructions.
- R8: A strobed class other than 2'b00 produces exactly one of `allow` and `undef_fault`. Every fault has `undef_is_disabled` high.
- R9: A write to the access-control register (`wr_sel` = 0) changes only bits 31, 23:22 and 21:20. All other bits keep their value.
- R10: A write to the exception register (`wr_sel` = 1) stores all 32 bits, including bit 31 and the implementation-defined bits 29:0, and they read back unchanged.
- R11: `init_req` sets bits 23:20 of the access-control register to 1 and sets bit 30 of the exception register, leaving other bits unchanged. It takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init_req | input | 1 | Startup request that opens floating-point access |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the access-control register, 1 the exception register |
| wr_data | input | 32 | Write data |
| cpu_mode | input | 5 | Current processor mode; 5'b10000 is user |
| insn_valid | input | 1 | Instruction issue strobe |
| insn_class | input | 2 | 00 other, 01 FP data, 10 FP system-register move, 11 SIMD |
| allow | output | 1 | Instruction may execute (registered) |
| undef_fault | output | 1 | Undefined-instruction fault pulse (registered) |
| undef_is_disabled | output | 1 | Fault cause is disabled access |
| acr_rd | output | 32 | Access-control register readback |
| fpx_rd | output | 32 | Exception register readback |

## Verification
A verdict is due on the clock edge after the strobe. The bench drives each strobe on a falling edge and reads the outputs on the next falling edge, when exactly one rising edge has passed. Register readback shows a write or an init request one edge after the request, so readback is sampled on the falling edge that follows. The same-cycle case drives a write together with a strobe and expects the verdict from the old register contents. A second strobe then sees the new contents.

// File: rtl/fpgate_pkg.sv
package fpgate_pkg;

    localparam int REG_W       = 32;
    localparam int TIER_LO     = 20;   // primary coprocessor permission tier
    localparam int TIER2_LO    = 22;   // secondary coprocessor permission tier
    localparam int SIMD_OFF_B  = 31;   // SIMD switch-off bit
    localparam int FPX_EN_B    = 30;   // global floating-point enable

    typedef enum logic [1:0] {
        CLS_OTHER  = 2'b00,
        CLS_FP     = 2'b01,
        CLS_SYSREG = 2'b10,
        CLS_SIMD   = 2'b11
    } insn_cls_e;

    typedef struct packed {
        logic [REG_W-1:0] acr;
        logic [REG_W-1:0] fpx;
    } ctrl_regs_t;

    typedef struct packed {
        logic allow;
        logic fault;
    } verdict_t;

endpackage

// File: rtl/fpgate_regs.sv
module fpgate_regs
    import fpgate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_req,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] acr_q,
    output logic [REG_W-1:0] fpx_q
);

    localparam logic [REG_W-1:0] ACR_WMASK =
        (REG_W'(1) << SIMD_OFF_B) | (REG_W'(3) << TIER2_LO) | (REG_W'(3) << TIER_LO);
    localparam logic [REG_W-1:0] ACR_OPEN  = (REG_W'(3) << TIER2_LO) | (REG_W'(3) << TIER_LO);
    localparam logic [REG_W-1:0] FPX_OPEN  = REG_W'(1) << FPX_EN_B;

    ctrl_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (init_req) begin
            st_d.acr = st_q.acr | ACR_OPEN;
            st_d.fpx = st_q.fpx | FPX_OPEN;
        end else if (wr_en) begin
            if (!wr_sel) begin
                st_d.acr = (st_q.acr & ~ACR_WMASK) | (wr_data & ACR_WMASK);
            end else begin
                st_d.fpx = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acr_q = st_q.acr;
    assign fpx_q = st_q.fpx;

endmodule

// File: rtl/fpgate_judge.sv
module fpgate_judge
    import fpgate_pkg::*;
#(
    parameter int                MODE_W    = 5,
    parameter logic [MODE_W-1:0] USER_MODE = 5'b10000
) (
    input  logic [1:0]        tier,
    input  logic              fp_en,
    input  logic              simd_off,
    input  logic [MODE_W-1:0] mode,
    input  insn_cls_e         cls,
    output logic              grant
);

    logic tier_ok;

    always_comb begin
        tier_ok = (tier == 2'b11) || ((tier == 2'b10) && (mode != USER_MODE));
        unique case (cls)
            CLS_FP:     grant = tier_ok && fp_en;
            CLS_SYSREG: grant = tier_ok;
            CLS_SIMD:   grant = tier_ok && fp_en && !simd_off;
            default:    grant = 1'b0;
        endcase
    end

endmodule

// File: rtl/fp_access_gate.sv
module fp_access_gate
    import fpgate_pkg::*;
#(
    parameter int                MODE_W    = 5,
    parameter logic [MODE_W-1:0] USER_MODE = 5'b10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_req,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [31:0]       wr_data,
    input  logic [MODE_W-1:0] cpu_mode,
    input  logic              insn_valid,
    input  logic [1:0]        insn_class,
    output logic              allow,
    output logic              undef_fault,
    output logic              undef_is_disabled,
    output logic [31:0]       acr_rd,
    output logic [31:0]       fpx_rd
);

    logic [REG_W-1:0] acr_q, fpx_q;
    logic             grant;
    insn_cls_e        cls;
    verdict_t         vd_d, vd_q;

    assign cls = insn_cls_e'(insn_class);

    fpgate_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_req (init_req),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .acr_q    (acr_q),
        .fpx_q    (fpx_q)
    );

    fpgate_judge #(.MODE_W(MODE_W), .USER_MODE(USER_MODE)) u_judge (
        .tier     (acr_q[TIER_LO +: 2]),
        .fp_en    (fpx_q[FPX_EN_B]),
        .simd_off (acr_q[SIMD_OFF_B]),
        .mode     (cpu_mode),
        .cls      (cls),
        .grant    (grant)
    );

    always_comb begin
        vd_d       = '0;
        if (insn_valid && (cls != CLS_OTHER)) begin
            vd_d.allow = grant;
            vd_d.fault = !grant;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign allow             = vd_q.allow;
    assign undef_fault       = vd_q.fault;
    assign undef_is_disabled = vd_q.fault;
    assign acr_rd            = acr_q;
    assign fpx_rd            = fpx_q;

endmodule

// File: rtl/fpgate_checker.sv
module fpgate_checker
    import fpgate_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        init_req,
    input logic        insn_valid,
    input logic [1:0]  insn_class,
    input logic        allow,
    input logic        undef_fault,
    input logic        undef_is_disabled,
    input logic [31:0] acr_rd,
    input logic [31:0] fpx_rd
);

    localparam logic [31:0] KEEP = ~((32'd1 << SIMD_OFF_B) | (32'd15 << TIER_LO));

    // R8: never both verdicts, faults always qualified
    a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        !(allow && undef_fault));
    a_r8_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        undef_fault |-> undef_is_disabled);

    // R7: silence without a strobe or for the other class
    a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(insn_valid) || ($past(insn_class) == 2'b00)) |-> (!allow && !undef_fault));

    // R5: full tier grants a system-register move whatever the enable bit
    a_r5_sysreg_tier: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_valid) && ($past(insn_class) == 2'b10)
         && ($past(acr_rd[TIER_LO +: 2]) == 2'b11)) |-> allow);

    // R6: SIMD switched off always faults
    a_r6_simd_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(insn_valid) && ($past(insn_class) == 2'b11)
         && $past(acr_rd[SIMD_OFF_B])) |-> undef_fault);

    // R9: unwritable access-control bits never move
    a_r9_keep_bits: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(acr_rd & KEEP));

    // R11: init opens both tiers and the enable bit
    a_r11_init_open: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(init_req)) |->
        ((acr_rd[TIER_LO +: 4] == 4'hF) && fpx_rd[FPX_EN_B]));

endmodule

bind fp_access_gate fpgate_checker u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .init_req          (init_req),
    .insn_valid        (insn_valid),
    .insn_class        (insn_class),
    .allow             (allow),
    .undef_fault       (undef_fault),
    .undef_is_disabled (undef_is_disabled),
    .acr_rd            (acr_rd),
    .fpx_rd            (fpx_rd)
);

// File: tb/tb_fp_access_gate.sv
`timescale 1ns/1ps
module tb_fp_access_gate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_req = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [4:0]  cpu_mode = 5'b10000;
    logic        insn_valid = 1'b0;
    logic [1:0]  insn_class = 2'b00;
    logic        allow, undef_fault, undef_is_disabled;
    logic [31:0] acr_rd, fpx_rd;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fp_access_gate dut (
        .clk(clk), .rst_n(rst_n), .init_req(init_req), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cpu_mode(cpu_mode), .insn_valid(insn_valid),
        .insn_class(insn_class), .allow(allow), .undef_fault(undef_fault),
        .undef_is_disabled(undef_is_disabled), .acr_rd(acr_rd), .fpx_rd(fpx_rd)
    );

    typedef struct packed {
        logic [31:0] acr;
        logic [31:0] fpx;
        logic [4:0]  mode;
        logic [1:0]  cls;
        logic        ok;
        logic        flt;
    } vec_t;

    localparam logic [4:0] USR = 5'b10000;
    localparam logic [4:0] SVC = 5'b10011;
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{32'h0030_0000, 32'h4000_0000, USR, 2'b01, 1'b1, 1'b0},  // R2
        '{32'h0030_0000, 32'h4000_0000, SVC, 2'b01, 1'b1, 1'b0},  // R2
        '{32'h0020_0000, 32'h4000_0000, USR, 2'b01, 1'b0, 1'b1},  // R3
        '{32'h0020_0000, 32'h4000_0000, SVC, 2'b01, 1'b1, 1'b0},  // R3
        '{32'h0010_0000, 32'h4000_0000, SVC, 2'b01, 1'b0, 1'b1},  // R3
        '{32'h0000_0000, 32'h4000_0000, SVC, 2'b10, 1'b0, 1'b1},  // R3
        '{32'h0030_0000, 32'h0000_0000, SVC, 2'b01, 1'b0, 1'b1},  // R4
        '{32'h0030_0000, 32'h0000_0000, USR, 2'b10, 1'b1, 1'b0},  // R5
        '{32'h0020_0000, 32'h0000_0000, USR, 2'b10, 1'b0, 1'b1},  // R5
        '{32'h0030_0000, 32'h4000_0000, USR, 2'b11, 1'b1, 1'b0},  // R6
        '{32'h8030_0000, 32'h4000_0000, USR, 2'b11, 1'b0, 1'b1},  // R6
        '{32'h8030_0000, 32'h4000_0000, USR, 2'b01, 1'b1, 1'b0},  // R6
        '{32'h0030_0000, 32'h4000_0000, USR, 2'b00, 1'b0, 1'b0},  // R7
        '{32'h0020_0000, 32'h0000_0000, SVC, 2'b11, 1'b0, 1'b1}   // R6
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic issue(input logic [1:0] cls, input logic [4:0] mode);
        @(negedge clk);
        insn_valid = 1'b1; insn_class = cls; cpu_mode = mode;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog got=hung exp=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 acr", acr_rd, 32'h0);
        chk("R1 fpx", fpx_rd, 32'h0);
        chk("R1 verdict", {30'd0, allow, undef_fault}, 32'h0);
        rst_n = 1'b1;

        // R1 check from reset registers: tier 0 denies
        issue(2'b10, SVC);
        chk("R1 tier0 fault", {30'd0, allow, undef_fault}, 32'h1);

        foreach (VECS[i]) begin
            wr(1'b0, VECS[i].acr);
            wr(1'b1, VECS[i].fpx);
            issue(VECS[i].cls, VECS[i].mode);
            chk($sformatf("R2-6 vec%0d allow/fault", i),
                {30'd0, allow, undef_fault}, {30'd0, VECS[i].ok, VECS[i].flt});
            if (VECS[i].flt) chk("R8 disabled qualifier", {31'd0, undef_is_disabled}, 32'h1);
            @(negedge clk);
            chk("R7 single pulse", {30'd0, allow, undef_fault}, 32'h0);
        end

        // R9: only the writable access-control bits take a write
        wr(1'b0, 32'h0000_0000);
        wr(1'b0, 32'hFFFF_FFFF);
        chk("R9 masked write", acr_rd, 32'h80F0_0000);
        wr(1'b0, 32'h0000_0000);
        chk("R9 clear", acr_rd, 32'h0);

        // R10: full exception register storage
        wr(1'b1, 32'hA5A5_5A5A);
        chk("R10 fpx store", fpx_rd, 32'hA5A5_5A5A);

        // R11: init opens access, keeps other bits, beats a write
        wr(1'b1, 32'h1234_5678);
        @(negedge clk);
        init_req = 1'b1; wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0;
        @(negedge clk);
        init_req = 1'b0; wr_en = 1'b0;
        chk("R11 acr open", acr_rd, 32'h00F0_0000);
        chk("R11 fpx enable", fpx_rd, 32'h5234_5678);
        issue(2'b11, USR);
        chk("R11 simd allowed", {30'd0, allow, undef_fault}, 32'h2);

        // R7: write in the strobe cycle affects only later instructions
        @(negedge clk);
        insn_valid = 1'b1; insn_class = 2'b01; cpu_mode = USR;
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0;
        @(negedge clk);
        insn_valid = 1'b0; wr_en = 1'b0;
        chk("R7 old contents used", {30'd0, allow, undef_fault}, 32'h2);
        issue(2'b01, USR);
        chk("R7 new contents used", {30'd0, allow, undef_fault}, 32'h1);

        // R7: no strobe, no verdict
        @(negedge clk);
        insn_class = 2'b01;
        @(negedge clk);
        chk("R7 idle", {30'd0, allow, undef_fault}, 32'h0);

        finish_run();
    end

endmodule